// File: doc/BRIEF.md
# Sector Symbol Error Patcher

This block finishes the error-correction work on one 512-byte sector after an external Reed-Solomon engine has produced its results. The sector sits in a local byte RAM that the block reaches through a simple read/write port. The RAM holds the data as a packed stream of 9-bit symbols. For a decode job, the engine supplies up to four located errors and an uncorrectable flag. The block flips the reported bits in place, with one read-modify-write of two bytes for each error. Before it does so, it checks whether the sector and its stored parity are fully erased (every byte 0xFF). An erased sector is left untouched and reported clean.

For an encode job, the block looks at the nine freshly computed parity bytes. If they match the parity that an all-0xFF sector produces, it replaces them with all-ones bytes, so that erased regions stay erased after partial programming. Otherwise the parity is passed on unchanged. A job starts with a one-cycle `start` and ends with a one-cycle `done`, which carries the result.

Top module: `sector_symfix`

## Requirements
- R1: Symbol index n (0-based) lives at byte address n + (n >> 3) with bit offset n & 7. A correction XORs its 9-bit mask into the 16-bit little-endian pair {byte addr+1, byte addr}, shifted left by that offset. In bit-stream terms, this flips bits 9n to 9n+8, where stream bit k is bit k & 7 of byte k >> 3.
- R2: Each error slot carries a 1-based position in a 10-bit field, so n = pos - 1. A slot is applied only when n lies in 0..511, that is pos in 1..512. Other slots are skipped: they cause no RAM access and are not counted.
- R3: Slots 0 to min(err_num, 4) - 1 are handled in ascending slot order. Slots at or above that count are ignored. `fixed_cnt` reports how many corrections were written.
- R4: On decode, if all nine parity bytes are 0xFF and all data bytes 0..511 read 0xFF, the job ends with fail = 0 and fixed_cnt = 0 and writes nothing, even when the uncorrectable flag is set.
- R5: On a decode that is not erased, with the uncorrectable flag set, the job ends with fail = 1 and fixed_cnt = 0, and the RAM is not written.
- R6: If any parity byte differs from 0xFF, the block makes no erased-check reads. The first RAM read of the job is the byte address of the first applied correction.
- R7: The erased check reads data bytes 0, 256 and 511 first, then bytes 1 to 510 in ascending order. It stops at the first byte that is not 0xFF, and corrections follow.
- R8: On encode, par_out is all ones when par_in equals the bytes CD 9D 90 58 F4 8B FF B7 6F, with byte 0 (CD) in par_in[7:0]. Otherwise par_out equals par_in. On decode, par_out equals par_in. An encode job raises done two clock edges after the start edge and makes no RAM access.
- R9: `done` is a one-cycle pulse. A `start` seen while busy is ignored.
- R10: After reset, busy, done, fail, fixed_cnt and par_out are zero and no RAM strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job (sampled when idle) |
| op_enc | input | 1 | 1 = encode job, 0 = decode job |
| err_num | input | 3 | Number of reported errors |
| err_uncor | input | 1 | Engine flagged the sector uncorrectable |
| err_pos | input | 40 | Four 10-bit 1-based symbol positions, slot 0 in the low bits |
| err_mask | input | 36 | Four 9-bit XOR masks, slot 0 in the low bits |
| par_in | input | 72 | Nine parity bytes, byte 0 in the low bits |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| fail | output | 1 | Sector uncorrectable (valid with done) |
| fixed_cnt | output | 3 | Corrections applied (valid with done) |
| par_out | output | 72 | Resulting parity bytes (valid from done) |
| ram_addr | output | 10 | Sector RAM byte address |
| ram_rd | output | 1 | RAM read strobe; data returns on the next cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |

## Verification
A wrong slot or position latch shows up within one job as a RAM write to the wrong byte or a changed `fixed_cnt`. The bench compares the whole RAM image with a model that works on the bit stream rather than on byte and offset arithmetic. Probe-sequence faults change the number of reads and the first addresses read, and these are logged from the RAM port in the same job. A stuck state machine or a wrong encode match shows on `done` timing or on `par_out` at the first `done` pulse.

// File: rtl/sfx_pkg.sv
// Shared constants and state encoding for the sector symbol patcher.
// Assumes a 512-byte sector packed as 9-bit symbols, with 9 parity bytes.
package sfx_pkg;
    localparam int SECT_BYTES = 512;
    localparam int NPAR       = 9;
    localparam int SYM_W      = 9;
    localparam int STREAM_B   = SECT_BYTES + SECT_BYTES / 8;
    localparam int ADDR_W     = $clog2(STREAM_B);

    // Parity that an all-0xFF sector produces; byte 0 in the low bits.
    localparam logic [NPAR*8-1:0] BLANK_PAR =
        {8'h6F, 8'hB7, 8'hFF, 8'h8B, 8'hF4, 8'h58, 8'h90, 8'h9D, 8'hCD};

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRB_RD, ST_PRB_CK, ST_JUDGE, ST_FX_SEL,
        ST_FX_RD0, ST_FX_RD1, ST_FX_WR0, ST_FX_WR1, ST_FIN
    } sfx_state_t;
endpackage

// File: rtl/sfx_sym_locate.sv
// Maps a 1-based reported symbol position to a byte address and bit offset.
// Assumes positions 1..SYM_N are legal; anything else is flagged not hit.
module sfx_sym_locate #(
    parameter int POS_W  = 10,
    parameter int ADDR_W = 10,
    parameter int SYM_N  = 512
) (
    input  logic [POS_W-1:0]  pos,
    output logic              hit,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        off
);
    logic [POS_W-1:0] idx;

    // Convert position to index, then to packed byte address and offset.
    always_comb begin
        idx  = pos - POS_W'(1);
        hit  = (pos != '0) && (pos <= POS_W'(SYM_N));
        addr = ADDR_W'(idx) + ADDR_W'(idx >> 3);
        off  = idx[2:0];
    end
endmodule

// File: rtl/sfx_par_guard.sv
// Substitutes all-ones parity for the blank-sector parity on encode jobs.
// Assumes the parity vector is ordered with byte 0 in the low bits.
module sfx_par_guard
    import sfx_pkg::*;
(
    input  logic [NPAR*8-1:0] par,
    input  logic              enc,
    output logic [NPAR*8-1:0] par_res
);
    // Replace a blank-sector match with erased bytes, only when encoding.
    always_comb begin
        par_res = (enc && (par == BLANK_PAR)) ? '1 : par;
    end
endmodule

// File: rtl/sector_symfix.sv
// Top of the sector symbol patcher: erased check, symbol correction and
// encode parity substitution over a byte RAM with one-cycle read latency.
// Assumes ram_rdata holds the byte addressed by the previous ram_rd cycle.
module sector_symfix
    import sfx_pkg::*;
#(
    parameter int NERR  = 4,
    parameter int POS_W = 10,
    localparam int CNT_W = $clog2(NERR + 1),
    localparam int IX_W  = (NERR > 1) ? $clog2(NERR) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  op_enc,
    input  logic [CNT_W-1:0]      err_num,
    input  logic                  err_uncor,
    input  logic [NERR*POS_W-1:0] err_pos,
    input  logic [NERR*SYM_W-1:0] err_mask,
    input  logic [NPAR*8-1:0]     par_in,
    output logic                  busy,
    output logic                  done,
    output logic                  fail,
    output logic [CNT_W-1:0]      fixed_cnt,
    output logic [NPAR*8-1:0]     par_out,
    output logic [ADDR_W-1:0]     ram_addr,
    output logic                  ram_rd,
    output logic                  ram_we,
    output logic [7:0]            ram_wdata,
    input  logic [7:0]            ram_rdata
);
    localparam logic [ADDR_W-1:0] LAST_STEP = ADDR_W'(SECT_BYTES);

    sfx_state_t           state;
    logic                 enc_q, uncor_q, fail_q;
    logic [CNT_W-1:0]     num_q, slot, fixed_q;
    logic [POS_W-1:0]     pos_q  [NERR];
    logic [SYM_W-1:0]     mask_q [NERR];
    logic [NPAR*8-1:0]    par_q, par_res;
    logic [ADDR_W-1:0]    step, probe_addr;
    logic [7:0]           lo_q, hi_q;
    logic [15:0]          pair;

    logic                 loc_hit  [NERR];
    logic [ADDR_W-1:0]    loc_addr [NERR];
    logic [2:0]           loc_off  [NERR];
    logic [IX_W-1:0]      slot_ix;

    genvar g;
    generate
        for (g = 0; g < NERR; g++) begin : g_loc
            sfx_sym_locate #(.POS_W(POS_W), .ADDR_W(ADDR_W), .SYM_N(SECT_BYTES)) u_loc (
                .pos  (pos_q[g]),
                .hit  (loc_hit[g]),
                .addr (loc_addr[g]),
                .off  (loc_off[g])
            );
        end
    endgenerate

    sfx_par_guard u_guard (.par(par_q), .enc(enc_q), .par_res(par_res));

    assign slot_ix = slot[IX_W-1:0];
    assign busy    = (state != ST_IDLE);

    // Erased-check address order: 0, middle, last, then 1..510.
    always_comb begin
        case (step)
            ADDR_W'(0): probe_addr = '0;
            ADDR_W'(1): probe_addr = ADDR_W'(SECT_BYTES / 2);
            ADDR_W'(2): probe_addr = ADDR_W'(SECT_BYTES - 1);
            default:    probe_addr = step - ADDR_W'(2);
        endcase
    end

    // Merge the corrected symbol into the two bytes read back.
    always_comb begin
        pair = {ram_rdata, lo_q} ^ (16'(mask_q[slot_ix]) << loc_off[slot_ix]);
    end

    // Drive the RAM port from the current state.
    always_comb begin
        ram_rd    = (state == ST_PRB_RD) || (state == ST_FX_RD0) || (state == ST_FX_RD1);
        ram_we    = (state == ST_FX_WR0) || (state == ST_FX_WR1);
        ram_wdata = (state == ST_FX_WR1) ? hi_q : pair[7:0];
        case (state)
            ST_PRB_RD:            ram_addr = probe_addr;
            ST_FX_RD0, ST_FX_WR0: ram_addr = loc_addr[slot_ix];
            ST_FX_RD1, ST_FX_WR1: ram_addr = loc_addr[slot_ix] + ADDR_W'(1);
            default:              ram_addr = '0;
        endcase
    end

    // Job sequencer: latch inputs, probe for erased, patch, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            enc_q     <= 1'b0;
            uncor_q   <= 1'b0;
            fail_q    <= 1'b0;
            num_q     <= '0;
            slot      <= '0;
            fixed_q   <= '0;
            par_q     <= '0;
            step      <= '0;
            lo_q      <= '0;
            hi_q      <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
            fixed_cnt <= '0;
            par_out   <= '0;
            for (int i = 0; i < NERR; i++) begin
                pos_q[i]  <= '0;
                mask_q[i] <= '0;
            end
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    enc_q   <= op_enc;
                    uncor_q <= err_uncor;
                    num_q   <= (err_num > CNT_W'(NERR)) ? CNT_W'(NERR) : err_num;
                    par_q   <= par_in;
                    fail_q  <= 1'b0;
                    fixed_q <= '0;
                    slot    <= '0;
                    step    <= '0;
                    for (int i = 0; i < NERR; i++) begin
                        pos_q[i]  <= err_pos[i*POS_W +: POS_W];
                        mask_q[i] <= err_mask[i*SYM_W +: SYM_W];
                    end
                    if (op_enc)        state <= ST_FIN;
                    else if (&par_in)  state <= ST_PRB_RD;
                    else               state <= ST_JUDGE;
                end
                ST_PRB_RD: state <= ST_PRB_CK;
                ST_PRB_CK: begin
                    if (ram_rdata != 8'hFF)     state <= ST_JUDGE;
                    else if (step == LAST_STEP) state <= ST_FIN;
                    else begin
                        step  <= step + ADDR_W'(1);
                        state <= ST_PRB_RD;
                    end
                end
                ST_JUDGE: begin
                    if (uncor_q) begin
                        fail_q <= 1'b1;
                        state  <= ST_FIN;
                    end else begin
                        state <= ST_FX_SEL;
                    end
                end
                ST_FX_SEL: begin
                    if (slot >= num_q)         state <= ST_FIN;
                    else if (loc_hit[slot_ix]) state <= ST_FX_RD0;
                    else                       slot  <= slot + CNT_W'(1);
                end
                ST_FX_RD0: state <= ST_FX_RD1;
                ST_FX_RD1: begin
                    lo_q  <= ram_rdata;
                    state <= ST_FX_WR0;
                end
                ST_FX_WR0: begin
                    hi_q  <= pair[15:8];
                    state <= ST_FX_WR1;
                end
                ST_FX_WR1: begin
                    fixed_q <= fixed_q + CNT_W'(1);
                    slot    <= slot + CNT_W'(1);
                    state   <= ST_FX_SEL;
                end
                ST_FIN: begin
                    done      <= 1'b1;
                    fail      <= fail_q;
                    fixed_cnt <= fixed_q;
                    par_out   <= par_res;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sector_symfix_chk.sv
// Port-level protocol checks for sector_symfix, attached by bind.
module sector_symfix_chk #(
    parameter int CNT_W = 3,
    parameter int NERR  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             op_enc,
    input logic             busy,
    input logic             done,
    input logic             fail,
    input logic [CNT_W-1:0] fixed_cnt,
    input logic             ram_rd,
    input logic             ram_we
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ram_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ram_rd && !ram_we));

    p_enc_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_enc) |=> ##1 done);

    p_fail_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (fixed_cnt == '0));

    p_rw_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !ram_rd);

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fixed_cnt <= CNT_W'(NERR)));
endmodule

bind sector_symfix sector_symfix_chk #(.CNT_W(CNT_W), .NERR(NERR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_enc    (op_enc),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fixed_cnt (fixed_cnt),
    .ram_rd    (ram_rd),
    .ram_we    (ram_we)
);

// File: tb/test_sector_symfix.sv
`timescale 1ns/1ps
module test_sector_symfix;
    localparam int NB = 576;
    localparam logic [71:0] BLANK =
        {8'h6F, 8'hB7, 8'hFF, 8'h8B, 8'hF4, 8'h58, 8'h90, 8'h9D, 8'hCD};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_enc = 1'b0, err_uncor = 1'b0;
    logic [2:0]  err_num = '0;
    logic [39:0] err_pos = '0;
    logic [35:0] err_mask = '0;
    logic [71:0] par_in = '0;
    logic        busy, done, fail, ram_rd, ram_we;
    logic [2:0]  fixed_cnt;
    logic [71:0] par_out;
    logic [9:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;

    logic [7:0]  mem [NB];
    logic [7:0]  img [NB];
    logic [7:0]  refm [NB];
    logic        load_req = 1'b0;
    int          nrd = 0, nwr = 0;
    logic [9:0]  rd_hist [2048];

    int checks = 0, failures = 0;
    int rd0, wr0, waited;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    sector_symfix i_sector_symfix (
        .clk(clk), .rst_n(rst_n), .start(start), .op_enc(op_enc),
        .err_num(err_num), .err_uncor(err_uncor), .err_pos(err_pos),
        .err_mask(err_mask), .par_in(par_in), .busy(busy), .done(done),
        .fail(fail), .fixed_cnt(fixed_cnt), .par_out(par_out),
        .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Byte RAM model with one-cycle read latency and access logging.
    always @(posedge clk) begin
        if (load_req) begin
            mem <= img;
        end else begin
            if (ram_we) begin
                if (int'(ram_addr) < NB) mem[ram_addr] <= ram_wdata;
                nwr <= nwr + 1;
            end
            if (ram_rd) begin
                ram_rdata <= (int'(ram_addr) < NB) ? mem[ram_addr] : 8'h00;
                rd_hist[nrd % 2048] <= ram_addr;
                nrd <= nrd + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_pattern(input int seed);
        for (int i = 0; i < NB; i++) img[i] = 8'((i * 7 + seed) & 8'h7F);
        load_commit();
    endtask

    task automatic load_blank();
        for (int i = 0; i < NB; i++) img[i] = 8'hFF;
        load_commit();
    endtask

    task automatic load_commit();
        for (int i = 0; i < NB; i++) refm[i] = img[i];
        @(negedge clk) load_req = 1'b1;
        @(negedge clk) load_req = 1'b0;
    endtask

    // Reference flip in bit-stream terms: symbol n occupies bits 9n..9n+8.
    task automatic ref_flip(input int n, input logic [8:0] m);
        for (int b = 0; b < 9; b++) begin
            int k;
            k = 9 * n + b;
            if (m[b]) refm[k / 8][k % 8] = ~refm[k / 8][k % 8];
        end
    endtask

    function automatic int mem_diff();
        int d;
        d = 0;
        for (int i = 0; i < NB; i++) if (mem[i] !== refm[i]) d++;
        return d;
    endfunction

    task automatic set_errs(input logic [9:0] p0, p1, p2, p3,
                            input logic [8:0] m0, m1, m2, m3);
        err_pos  = {p3, p2, p1, p0};
        err_mask = {m3, m2, m1, m0};
    endtask

    task automatic go();
        @(negedge clk);
        rd0 = nrd; wr0 = nwr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 1;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check(done, "R9 done seen", done, 1);
        @(negedge clk);
        check(!done, "R9 done one cycle", done, 0);
        // step back to report fields captured with done (held until next job)
    endtask

    task automatic t_reset();
        check(busy == 0 && done == 0, "R10 busy/done", {busy, done}, 0);
        check(fail == 0 && fixed_cnt == 0, "R10 fail/cnt", {fail, fixed_cnt}, 0);
        check(par_out == '0, "R10 par_out", par_out[31:0], 0);
        check(!ram_rd && !ram_we, "R10 ram idle", {ram_rd, ram_we}, 0);
    endtask

    task automatic t_straddle();
        load_pattern(3);
        op_enc = 0; err_uncor = 0; err_num = 2; par_in = 72'h0123456789ABCDEF01;
        set_errs(10'd1, 10'd8, 10'd0, 10'd0, 9'h1FF, 9'h155, 9'h0, 9'h0);
        ref_flip(0, 9'h1FF); ref_flip(7, 9'h155);
        go();
        check(fixed_cnt == 2 && !fail, "R1 count", fixed_cnt, 2);
        check(mem_diff() == 0, "R1 straddle image", mem_diff(), 0);
        check(rd_hist[rd0 % 2048] == 10'd0, "R6 first read addr", rd_hist[rd0 % 2048], 0);
        check(nrd - rd0 == 4 && nwr - wr0 == 4, "R6 no probe reads", nrd - rd0, 4);
        check(par_out == par_in, "R8 decode par pass", par_out[31:0], par_in[31:0]);
    endtask

    task automatic t_four();
        load_pattern(40);
        err_uncor = 0; err_num = 4; par_in = 72'h00FF00FF00FF00FF00;
        set_errs(10'd10, 10'd11, 10'd512, 10'd300, 9'h0A5, 9'h13C, 9'h1FF, 9'h001);
        ref_flip(9, 9'h0A5); ref_flip(10, 9'h13C); ref_flip(511, 9'h1FF); ref_flip(299, 9'h001);
        go();
        check(fixed_cnt == 4, "R3 four applied", fixed_cnt, 4);
        check(mem_diff() == 0, "R1 adjacent+last image", mem_diff(), 0);
        check(rd_hist[rd0 % 2048] == 10'd10, "R6 first read slot0", rd_hist[rd0 % 2048], 10);
    endtask

    task automatic t_range();
        load_pattern(77);
        err_uncor = 0; err_num = 4; par_in = 72'h5;
        set_errs(10'd0, 10'd513, 10'd1023, 10'd5, 9'h1FF, 9'h1FF, 9'h1FF, 9'h0F0);
        ref_flip(4, 9'h0F0);
        go();
        check(fixed_cnt == 1, "R2 only in-range counted", fixed_cnt, 1);
        check(mem_diff() == 0, "R2 image", mem_diff(), 0);
        check(nwr - wr0 == 2, "R2 writes", nwr - wr0, 2);
    endtask

    task automatic t_count();
        load_pattern(9);
        err_uncor = 0; err_num = 2; par_in = 72'h7;
        set_errs(10'd20, 10'd21, 10'd22, 10'd23, 9'h011, 9'h022, 9'h044, 9'h088);
        ref_flip(19, 9'h011); ref_flip(20, 9'h022);
        go();
        check(fixed_cnt == 2, "R3 err_num limits", fixed_cnt, 2);
        check(mem_diff() == 0, "R3 image num=2", mem_diff(), 0);
        load_pattern(9);
        err_num = 7;
        ref_flip(19, 9'h011); ref_flip(20, 9'h022); ref_flip(21, 9'h044); ref_flip(22, 9'h088);
        go();
        check(fixed_cnt == 4, "R3 err_num capped", fixed_cnt, 4);
        check(mem_diff() == 0, "R3 image capped", mem_diff(), 0);
    endtask

    task automatic t_erased();
        load_blank();
        err_uncor = 1; err_num = 2; par_in = '1;
        set_errs(10'd1, 10'd2, 10'd0, 10'd0, 9'h1FF, 9'h1FF, 9'h0, 9'h0);
        go();
        check(fixed_cnt == 0 && !fail, "R4 erased clean", {fail, fixed_cnt}, 0);
        check(nwr - wr0 == 0, "R4 no writes", nwr - wr0, 0);
        check(mem_diff() == 0, "R4 image", mem_diff(), 0);
        check(nrd - rd0 == 513, "R7 full scan reads", nrd - rd0, 513);
    endtask

    task automatic t_probe();
        for (int i = 0; i < NB; i++) img[i] = 8'hFF;
        img[511] = 8'h00;
        load_commit();
        err_uncor = 0; err_num = 1; par_in = '1;
        set_errs(10'd3, 10'd0, 10'd0, 10'd0, 9'h101, 9'h0, 9'h0, 9'h0);
        ref_flip(2, 9'h101);
        go();
        check(rd_hist[rd0 % 2048] == 0 && rd_hist[(rd0 + 1) % 2048] == 256 &&
              rd_hist[(rd0 + 2) % 2048] == 511, "R7 probe order",
              rd_hist[(rd0 + 1) % 2048], 256);
        check(nrd - rd0 == 5 && fixed_cnt == 1, "R7 stop after last probe", nrd - rd0, 5);
        check(mem_diff() == 0, "R7 image", mem_diff(), 0);
        for (int i = 0; i < NB; i++) img[i] = 8'hFF;
        img[300] = 8'h7F;
        load_commit();
        ref_flip(2, 9'h101);
        go();
        check(nrd - rd0 == 305, "R7 scan stops at 300", nrd - rd0, 305);
        check(rd_hist[(rd0 + 3) % 2048] == 1, "R7 scan starts at 1", rd_hist[(rd0 + 3) % 2048], 1);
    endtask

    task automatic t_uncor();
        load_pattern(55);
        err_uncor = 1; err_num = 3; par_in = 72'h12;
        set_errs(10'd1, 10'd2, 10'd3, 10'd0, 9'h1FF, 9'h1FF, 9'h1FF, 9'h0);
        go();
        check(fail && fixed_cnt == 0, "R5 fail reported", {fail, fixed_cnt}, 8);
        check(nwr - wr0 == 0 && nrd - rd0 == 0, "R5 no ram access", nwr - wr0, 0);
        check(mem_diff() == 0, "R5 image", mem_diff(), 0);
    endtask

    task automatic t_encode();
        op_enc = 1; err_uncor = 0; err_num = 0; par_in = BLANK;
        go();
        check(par_out == '1, "R8 blank parity to ones", par_out[31:0], 32'hFFFFFFFF);
        check(waited == 2, "R8 encode latency", waited, 2);
        check(nrd - rd0 == 0 && nwr - wr0 == 0, "R8 no ram access", nrd - rd0, 0);
        par_in = BLANK ^ 72'h1;
        go();
        check(par_out == par_in, "R8 near-miss unchanged", par_out[31:0], par_in[31:0]);
        op_enc = 0;
    endtask

    task automatic t_busy();
        int ndone;
        load_blank();
        op_enc = 0; err_uncor = 0; err_num = 0; par_in = '1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (5) @(negedge clk);
        op_enc = 1; start = 1'b1;
        @(negedge clk) start = 1'b0; op_enc = 0;
        ndone = 0;
        for (int c = 0; c < 1200; c++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        check(ndone == 1, "R9 start while busy ignored", ndone, 1);
        check(!busy, "R9 idle after job", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_straddle();
        t_four();
        t_range();
        t_count();
        t_erased();
        t_probe();
        t_uncor();
        t_encode();
        t_busy();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule